// File: doc/BRIEF.md
# Codec Command Ring Enqueue Engine

This block keeps a circular ring of 32-bit codec command words in local storage. A host offers one command at a time with a valid/ready handshake. One cycle later the block reports whether the command was stored, must be retried because the ring is full, or was refused because the device is powered down. Before storing a command, the block steps the write pointer forward by one, modulo the ring depth. The command then lands at that new index. Right after reset, the first command therefore goes into slot 1, not slot 0.

A consumer drains the ring through a pop port. The entry it sees is always the one just past the read pointer, and it can only advance while the run input is high. Software can restart the read pointer with a two-step handshake. Writing a one raises a pending flag, which shows in the top bit of the read-pointer view. Writing a zero afterwards clears the pointer and the flag together. For each codec address, the block also counts commands that were accepted but not yet answered, and it holds the last command accepted for that address. A response stage reads these and acknowledges each answer.

Top module: `cmd_ring_enq`

## Requirements
- R1: A synchronous reset clears both pointers, the reset-pending flag, `resp_valid`, every outstanding count and every last-command word to 0.
- R2: A command taken while powered up, with a ring that is not full, moves the write pointer to (wp+1) mod depth and is stored at that new index. The next cycle shows `resp_valid`=1 with `resp_code`=0 (accepted).
- R3: When (wp+1) mod depth equals the read pointer, a taken command is rejected with `resp_code`=1 (retry). Nothing is stored, and neither pointer nor any count changes.
- R4: While `pwr_down` is high, `wp_view` reads 16'hFFFF and a taken command is refused with `resp_code`=2 (I/O error), with no state change.
- R5: The codec address is bits 31:28 of the command; a value of `NUM_CODECS` or more is treated as address 0. An accepted command records itself as that codec's last command.
- R6: Each codec has a saturating outstanding count. It goes up by one when a command is accepted for that codec. It goes down by one when `rsp_ack` names that codec and the count is nonzero. Both in the same cycle leave it unchanged. An acknowledge to an address of `NUM_CODECS` or more does nothing.
- R7: Writing 1 through `rp_rst_wr`/`rp_rst_val` sets bit 15 of `rp_view` and holds `cmd_ready` and `pop_valid` low. A later write of 0 clears the read pointer and bit 15. A write of 0 with nothing pending changes nothing.
- R8: `pop_valid` is high when the run input is set, no reset is pending and rp differs from wp. `pop_data` is then the entry at (rp+1) mod depth, and a pop advances rp by one.
- R9: With `run_en` low, `pop_valid` stays low and `pop_req` leaves the read pointer unchanged.
- R10: Both pointers wrap from depth-1 to 0; with the default size code 2 the ring holds 256 entries, and `wp_view`/`rp_view` carry the pointer in their low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Command can be taken (low while a pointer reset is pending) |
| cmd_data | input | CMD_W | Command word, codec address in the top nibble |
| pwr_down | input | 1 | Device powered down |
| resp_valid | output | 1 | Status for the command taken last cycle |
| resp_code | output | 2 | 0 accepted, 1 retry, 2 I/O error |
| rp_rst_wr | input | 1 | Write strobe to the read-pointer reset bit |
| rp_rst_val | input | 1 | Value written to the reset bit |
| run_en | input | 1 | Consumer run enable |
| pop_req | input | 1 | Consumer takes the offered entry |
| pop_valid | output | 1 | An entry is offered |
| pop_data | output | CMD_W | Entry at read pointer + 1 |
| rsp_ack | input | 1 | Response stage retires one command |
| rsp_addr | input | 4 | Codec address of the retired command |
| wp_view | output | 16 | Write pointer, or all ones when powered down |
| rp_view | output | 16 | Bit 15 reset pending, low bits read pointer |
| outst_cnt | output | NUM_CODECS*CNT_W | Outstanding counts, codec n at bits n*CNT_W |
| last_cmd | output | NUM_CODECS*CMD_W | Last accepted command per codec |

## Verification
The hardest state to reach is a full ring. The bench reaches it by holding the consumer stopped while it offers more commands than the ring can hold. It then checks the exact command where retries begin, while acknowledges to both valid and out-of-range addresses run in parallel. Wrap-around comes next: the run input is raised and entries are popped while new commands keep arriving. The pointer-reset handshake is driven last, after the write pointer sits away from zero. This shows the ring offering stale slots once the read pointer has been cleared on its own.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
   typedef enum logic [1:0] {
      ENQ_OK    = 2'd0,
      ENQ_RETRY = 2'd1,
      ENQ_IOERR = 2'd2
   } enq_status_e;

   localparam int CODEC_NIB_W = 4;
   localparam int VIEW_W      = 16;

   // ring size code -> log2 of entry count
   function automatic int ring_log2(input int code);
      case (code)
         0:       return 1;
         1:       return 4;
         default: return 8;
      endcase
   endfunction
endpackage

// File: rtl/cmd_ring_ptrs.sv
module cmd_ring_ptrs #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          enq_fire,
   input  logic          pop_fire,
   input  logic          clr_wr,
   input  logic          clr_val,
   output logic [PW-1:0] wp,
   output logic [PW-1:0] rp,
   output logic          clr_pend
);
   localparam logic [PW-1:0] ONE = 1;

   always_ff @(posedge clk) begin
      if (rst) begin
         wp       <= '0;
         rp       <= '0;
         clr_pend <= 1'b0;
      end else begin
         if (enq_fire) wp <= wp + ONE;
         if (clr_wr && !clr_val && clr_pend) rp <= '0;
         else if (pop_fire)                  rp <= rp + ONE;
         if (clr_wr) clr_pend <= clr_val;
      end
   end
endmodule

// File: rtl/cmd_ring_store.sv
module cmd_ring_store #(
   parameter int PW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [PW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << PW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cmd_ring_codec_track.sv
module cmd_ring_codec_track #(
   parameter int NC = 4,
   parameter int CW = 8,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            acc,
   input  logic [3:0]      acc_addr,
   input  logic [DW-1:0]   acc_cmd,
   input  logic            ack,
   input  logic [3:0]      ack_addr,
   output logic [NC*CW-1:0] cnt_flat,
   output logic [NC*DW-1:0] last_flat
);
   localparam logic [CW-1:0] ONE  = 1;
   localparam logic [CW-1:0] CMAX = '1;

   for (genvar g = 0; g < NC; g++) begin : g_codec
      logic [CW-1:0] cnt;
      logic [DW-1:0] last;
      logic          hit, inc, dec;

      assign hit = acc && (acc_addr == 4'(g));
      assign inc = hit && (cnt != CMAX);
      assign dec = ack && (ack_addr == 4'(g)) && (cnt != '0);

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt  <= '0;
            last <= '0;
         end else begin
            case ({inc, dec})
               2'b10:   cnt <= cnt + ONE;
               2'b01:   cnt <= cnt - ONE;
               default: cnt <= cnt;
            endcase
            if (hit) last <= acc_cmd;
         end
      end

      assign cnt_flat[g*CW +: CW]  = cnt;
      assign last_flat[g*DW +: DW] = last;
   end
endmodule

// File: rtl/cmd_ring_enq.sv
module cmd_ring_enq
   import cmd_ring_pkg::*;
#(
   parameter int SIZE_CODE  = 2,
   parameter int NUM_CODECS = 4,
   parameter int CNT_W      = 8,
   parameter int CMD_W      = 32
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        cmd_valid,
   output logic                        cmd_ready,
   input  logic [CMD_W-1:0]            cmd_data,
   input  logic                        pwr_down,
   output logic                        resp_valid,
   output logic [1:0]                  resp_code,
   input  logic                        rp_rst_wr,
   input  logic                        rp_rst_val,
   input  logic                        run_en,
   input  logic                        pop_req,
   output logic                        pop_valid,
   output logic [CMD_W-1:0]            pop_data,
   input  logic                        rsp_ack,
   input  logic [3:0]                  rsp_addr,
   output logic [15:0]                 wp_view,
   output logic [15:0]                 rp_view,
   output logic [NUM_CODECS*CNT_W-1:0] outst_cnt,
   output logic [NUM_CODECS*CMD_W-1:0] last_cmd
);
   localparam int PW = ring_log2(SIZE_CODE);
   localparam logic [PW-1:0] ONE = 1;
   localparam logic [4:0] NC5 = 5'(NUM_CODECS);

   if (SIZE_CODE < 0 || SIZE_CODE > 2)
      $error("SIZE_CODE must be 0, 1 or 2");
   if (NUM_CODECS < 1 || NUM_CODECS > 16)
      $error("NUM_CODECS must be 1..16");
   if (CMD_W < 8)
      $error("CMD_W too small for an address nibble");
   if (CNT_W < 1)
      $error("CNT_W must be positive");

   logic [PW-1:0] wp, rp, wp_nx;
   logic          rp_pend, take, full, accept, pop_fire;
   logic [3:0]    nib, codec;
   enq_status_e   st_q;

   assign cmd_ready = ~rp_pend;
   assign take      = cmd_valid & cmd_ready;
   assign wp_nx     = wp + ONE;
   assign full      = (wp_nx == rp);
   assign accept    = take & ~pwr_down & ~full;

   assign pop_valid = run_en & ~rp_pend & (rp != wp);
   assign pop_fire  = pop_req & pop_valid;

   assign nib   = cmd_data[CMD_W-1 -: 4];
   assign codec = ({1'b0, nib} < NC5) ? nib : 4'd0;

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_valid <= 1'b0;
         st_q       <= ENQ_OK;
      end else begin
         resp_valid <= take;
         if (take) st_q <= pwr_down ? ENQ_IOERR : (full ? ENQ_RETRY : ENQ_OK);
      end
   end
   assign resp_code = st_q;

   cmd_ring_ptrs #(.PW(PW)) u_ptrs (
      .clk(clk), .rst(rst), .enq_fire(accept), .pop_fire(pop_fire),
      .clr_wr(rp_rst_wr), .clr_val(rp_rst_val),
      .wp(wp), .rp(rp), .clr_pend(rp_pend)
   );

   cmd_ring_store #(.PW(PW), .DW(CMD_W)) u_store (
      .clk(clk), .we(accept), .waddr(wp_nx), .wdata(cmd_data),
      .raddr(rp + ONE), .rdata(pop_data)
   );

   cmd_ring_codec_track #(.NC(NUM_CODECS), .CW(CNT_W), .DW(CMD_W)) u_track (
      .clk(clk), .rst(rst), .acc(accept), .acc_addr(codec), .acc_cmd(cmd_data),
      .ack(rsp_ack), .ack_addr(rsp_addr),
      .cnt_flat(outst_cnt), .last_flat(last_cmd)
   );

   assign wp_view = pwr_down ? 16'hFFFF : 16'(wp);
   assign rp_view = {rp_pend, 15'(rp)};
endmodule

// File: rtl/cmd_ring_enq_chk.sv
module cmd_ring_enq_chk #(
   parameter int PW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic          pwr_down,
   input logic          resp_valid,
   input logic [1:0]    resp_code,
   input logic          run_en,
   input logic          pop_req,
   input logic          pop_valid,
   input logic          rp_rst_wr,
   input logic [PW-1:0] wp,
   input logic [PW-1:0] rp,
   input logic          rp_pend
);
   localparam logic [PW-1:0] ONE = 1;

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (rp == '0 && wp == '0 && !rp_pend && !resp_valid));

   p_accept_step_r2: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ready && !pwr_down && (PW'(wp + ONE) != rp))
      |=> (resp_valid && resp_code == 2'd0 && wp == PW'($past(wp) + ONE)));

   p_full_retry_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ready && !pwr_down && (PW'(wp + ONE) == rp))
      |=> (resp_valid && resp_code == 2'd1 && $stable(wp)));

   p_powerdown_r4: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ready && pwr_down)
      |=> (resp_valid && resp_code == 2'd2 && $stable(wp)));

   p_pending_blocks_r7: assert property (@(posedge clk) disable iff (rst)
      rp_pend |-> (!cmd_ready && !pop_valid));

   p_pop_step_r8: assert property (@(posedge clk) disable iff (rst)
      (pop_req && pop_valid && !rp_rst_wr) |=> (rp == PW'($past(rp) + ONE)));

   p_stopped_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!run_en && !rp_rst_wr) |=> $stable(rp));
endmodule

bind cmd_ring_enq cmd_ring_enq_chk #(.PW(PW)) u_chk (
   .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .pwr_down(pwr_down), .resp_valid(resp_valid), .resp_code(resp_code),
   .run_en(run_en), .pop_req(pop_req), .pop_valid(pop_valid),
   .rp_rst_wr(rp_rst_wr), .wp(wp), .rp(rp), .rp_pend(rp_pend)
);

// File: tb/cmd_ring_enq_test.sv
`timescale 1ns/1ps
module cmd_ring_enq_test;
   localparam int D  = 256;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0, pwr_down = 1'b0;
   logic [31:0] cmd_data = '0;
   logic        rp_rst_wr = 1'b0, rp_rst_val = 1'b0;
   logic        run_en = 1'b0, pop_req = 1'b0, rsp_ack = 1'b0;
   logic [3:0]  rsp_addr = '0;
   logic        cmd_ready, resp_valid, pop_valid;
   logic [1:0]  resp_code;
   logic [31:0] pop_data;
   logic [15:0] wp_view, rp_view;
   logic [NC*8-1:0]  outst_cnt;
   logic [NC*32-1:0] last_cmd;

   int checks = 0, fails = 0;
   bit started = 0, done = 0;

   always #2.5 clk = ~clk;

   cmd_ring_enq uut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_data(cmd_data), .pwr_down(pwr_down), .resp_valid(resp_valid),
      .resp_code(resp_code), .rp_rst_wr(rp_rst_wr), .rp_rst_val(rp_rst_val),
      .run_en(run_en), .pop_req(pop_req), .pop_valid(pop_valid),
      .pop_data(pop_data), .rsp_ack(rsp_ack), .rsp_addr(rsp_addr),
      .wp_view(wp_view), .rp_view(rp_view), .outst_cnt(outst_cnt),
      .last_cmd(last_cmd)
   );

   // reference model
   int          m_wp, m_rp, m_rc;
   bit          m_flag, m_rv;
   logic [31:0] m_mem [D];
   bit          m_known [D];
   int          m_cnt [NC];
   logic [31:0] m_last [NC];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int owp, orp, a, inc_a, nw;
      bit ofl, take;
      started = 1;
      if (rst) begin
         m_wp = 0; m_rp = 0; m_flag = 0; m_rv = 0; m_rc = 0;
         for (int c = 0; c < NC; c++) begin m_cnt[c] = 0; m_last[c] = '0; end
         for (int i = 0; i < D; i++) m_known[i] = 0;
      end else begin
         owp = m_wp; orp = m_rp; ofl = m_flag; inc_a = -1;
         take = cmd_valid && !ofl;
         m_rv = take;
         if (take) begin
            nw = (owp + 1) % D;
            if (pwr_down) m_rc = 2;
            else if (nw == orp) m_rc = 1;
            else begin
               m_rc = 0;
               m_mem[nw] = cmd_data; m_known[nw] = 1; m_wp = nw;
               a = int'(cmd_data[31:28]);
               if (a >= NC) a = 0;
               inc_a = a; m_last[a] = cmd_data;
            end
         end
         if (pop_req && run_en && !ofl && orp != owp) m_rp = (orp + 1) % D;
         if (rp_rst_wr) begin
            if (rp_rst_val) m_flag = 1;
            else if (ofl) begin m_flag = 0; m_rp = 0; end
         end
         for (int c = 0; c < NC; c++) begin
            int ov;
            bit inc, dec;
            ov  = m_cnt[c];
            inc = (inc_a == c) && (ov != 255);
            dec = rsp_ack && (int'(rsp_addr) == c) && (ov != 0);
            m_cnt[c] = ov + int'(inc) - int'(dec);
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         int rn;
         chk("R2 resp_valid", 32'(resp_valid), 32'(m_rv));
         if (m_rv)
            chk(m_rc == 1 ? "R3 resp_code" : (m_rc == 2 ? "R4 resp_code" : "R2 resp_code"),
                32'(resp_code), 32'(m_rc));
         chk(pwr_down ? "R4 wp_view" : "R10 wp_view", 32'(wp_view),
             pwr_down ? 32'hFFFF : 32'(m_wp));
         chk("R7 rp_view", 32'(rp_view), 32'(m_rp) | (m_flag ? 32'h8000 : 32'h0));
         chk("R7 cmd_ready", 32'(cmd_ready), 32'(!m_flag));
         chk(run_en ? "R8 pop_valid" : "R9 pop_valid", 32'(pop_valid),
             32'(run_en && !m_flag && m_rp != m_wp));
         rn = (m_rp + 1) % D;
         if (pop_valid && m_known[rn]) chk("R8 pop_data", pop_data, m_mem[rn]);
         for (int c = 0; c < NC; c++) begin
            chk("R6 outst_cnt", 32'(outst_cnt[c*8 +: 8]), 32'(m_cnt[c]));
            chk("R5 last_cmd", last_cmd[c*32 +: 32], m_last[c]);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic finish_run();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [3:0] nibs [6];
      nibs = '{4'h1, 4'h3, 4'h5, 4'hF, 4'h0, 4'h2};
      step(3);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset wp", 32'(wp_view), 32'h0);
      chk("R1 reset rp", 32'(rp_view), 32'h0);
      chk("R1 reset cnt", 32'(outst_cnt), 32'h0);
      step(1);

      // stopped consumer: pop_req ignored (R9), out-of-range nibbles forced to 0 (R5)
      pop_req = 1'b1;
      for (int i = 0; i < 6; i++) begin
         cmd_valid = 1'b1; cmd_data = {nibs[i], 28'h0ABC000 + 28'(i)};
         step(1);
      end
      cmd_valid = 1'b0;
      step(3);

      // consume (R8), then a clear-write of 0 with nothing pending (R7)
      run_en = 1'b1;
      step(8);
      rp_rst_wr = 1'b1; rp_rst_val = 1'b0; step(1); rp_rst_wr = 1'b0;
      run_en = 1'b0; pop_req = 1'b0;

      // fill past capacity with acks alongside (R3, R6)
      for (int i = 0; i < 262; i++) begin
         cmd_valid = 1'b1; cmd_data = {4'(i % 16), 28'(i * 7 + 1)};
         rsp_ack = (i % 5 == 0); rsp_addr = 4'(i % 6);
         step(1);
      end
      cmd_valid = 1'b0; rsp_ack = 1'b0;

      // powered down (R4)
      pwr_down = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cmd_valid = (i != 1); cmd_data = 32'h1234_5678; step(1);
      end
      cmd_valid = 1'b0; step(1); pwr_down = 1'b0;

      // drain while enqueuing, pointers wrap (R10)
      run_en = 1'b1; pop_req = 1'b1;
      for (int i = 0; i < 320; i++) begin
         cmd_valid = (i % 3 != 0); cmd_data = {4'(i % 5), 28'(i + 32'h100)};
         step(1);
      end
      cmd_valid = 1'b0;

      // retire outstanding, including same-cycle accept and ack on one codec (R6)
      for (int i = 0; i < 300; i++) begin
         rsp_ack = 1'b1; rsp_addr = 4'(i % NC);
         cmd_valid = (i % 7 == 0); cmd_data = {4'(i % NC), 28'(i)};
         step(1);
      end
      rsp_ack = 1'b0; cmd_valid = 1'b0;

      // put wp away from zero, then the pointer reset handshake (R7)
      run_en = 1'b0; pop_req = 1'b0;
      for (int i = 0; i < 5; i++) begin
         cmd_valid = 1'b1; cmd_data = {4'h2, 28'(i + 32'h55)}; step(1);
      end
      cmd_valid = 1'b0;
      run_en = 1'b1;
      rp_rst_wr = 1'b1; rp_rst_val = 1'b1; step(1); rp_rst_wr = 1'b0;
      cmd_valid = 1'b1; pop_req = 1'b1; cmd_data = 32'h2FFF_0000; step(2);
      cmd_valid = 1'b0;
      rp_rst_wr = 1'b1; rp_rst_val = 1'b0; step(1); rp_rst_wr = 1'b0;
      step(20);
      run_en = 1'b0; pop_req = 1'b0;
      step(3);
      finish_run();
   end
endmodule